// File: doc/BRIEF.md
# Multi-channel down-counting event timer

This block is a bank of independent 64-bit event timers that count down on the bus clock. Software reaches it through a small word-addressed register window. The window is driven by a one-cycle strobe, and read data comes back registered on the following cycle. Each channel has a control word, a 64-bit interval split into low and high words, and a readable 64-bit current count. A per-channel prescaler slows the count rate by a power of two. This is done with a tick enable, and no derived clock is generated.

When a channel reaches its expiry point, it raises a pending bit in a shared status register. In periodic mode the channel then reloads its interval and keeps counting. In one-shot mode it clears its own enable and stops. A shared enable register gates each pending bit onto that channel's own interrupt line. Clearing a channel's enable does not stop it at once: the counter runs on for two more clock cycles first.

The channel count is a parameter, 2 or 4. The asynchronous active-low reset is released through a two-flop synchronizer, so the block comes out of reset two clock edges after the reset input rises.

Top module: `evtmr_bank`

## Requirements
- R1: After reset, every register reads zero, the read data output is zero and every interrupt line is low.
- R2: The register map is fixed. Interrupt enable is at 0x00 and status at 0x04. Channel n has its control word at 0x10+0x20·n, its interval low and high words at +0x4 and +0x8, and its count low and high words at +0xC and +0x10. In the control word, bit 0 is enable, bit 1 is reload, bits 6:4 are the prescale select and bit 7 selects one-shot. Read data appears on the cycle after the read strobe. A control write with bit 1 set copies the 64-bit interval into the counter on that edge, and bit 1 always reads back 0.
- R3: With prescale 0, a running channel's count drops by exactly one on every clock edge, starting with the first edge after the starting write.
- R4: With prescale select p, the count drops once per 2^p clock edges. The first drop is on the 2^p-th edge after the reload.
- R5: When a channel in periodic mode gets a count tick while its count is zero, it sets its pending bit, reloads the interval, and keeps counting. The period is therefore interval+1 ticks.
- R6: When a channel in one-shot mode gets a count tick while its count is zero, it sets its pending bit, clears its own enable bit (bit 7 stays set), and holds the count at zero.
- R7: After a write clears enable, the counter still counts on that edge and on the next two edges. After that it holds its value.
- R8: A pending bit is set on expiry whether or not its interrupt is enabled. Interrupt line n is high exactly while pending bit n and enable bit n are both set.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry happens on the same edge as a clear, the bit stays set.
- R10: The counter is 64 bits wide and borrows across the 32-bit word boundary. An interval with only the low word written (high word zero) counts as a 32-bit value.
- R11: Reading a channel's count low word captures that channel's count high word in a shadow register. A later high-word read returns the shadow, not the live value.
- R12: Channels are independent. Activity on one channel leaves another channel's control word and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | AW (12) | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |
| irq | output | NCH (4) | One interrupt line per channel |

## Verification
A register write takes effect on the edge that samples it. Read data is registered, so a read strobe sampled at edge k returns the state as it stood after edge k-1. The bench counts every edge from the write that starts a channel. A read issued after n idle edges therefore expects the interval minus n at prescale 0, one count per four edges at prescale 2, and a reload on the tick after zero. Expected words are queued when the read is issued and compared on the falling edge after the data arrives. Interrupt lines are compared directly, one cycle after the write or expiry that moves them.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int BUS_W = 32;
  localparam int PRE_W = 3;

  // control word field positions
  localparam int BIT_EN  = 0;
  localparam int BIT_RLD = 1;
  localparam int BIT_PRE = 4;
  localparam int BIT_OS  = 7;

  // address map
  localparam int OFS_IE     = 'h00;
  localparam int OFS_ST     = 'h04;
  localparam int OFS_CH0    = 'h10;
  localparam int CH_STRIDE  = 'h20;
  localparam int SUB_CTRL   = 'h0;
  localparam int SUB_IVL_LO = 'h4;
  localparam int SUB_IVL_HI = 'h8;
  localparam int SUB_CNT_LO = 'hC;
  localparam int SUB_CNT_HI = 'h10;

  typedef struct packed {
    logic             one_shot;
    logic [PRE_W-1:0] pre;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [BUS_W-1:0] w);
    ctrl_t c;
    c.en       = w[BIT_EN];
    c.pre      = w[BIT_PRE +: PRE_W];
    c.one_shot = w[BIT_OS];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[BIT_EN]            = c.en;
    w[BIT_PRE +: PRE_W]  = c.pre;
    w[BIT_OS]            = c.one_shot;
    return w;
  endfunction
endpackage

// File: rtl/evtmr_tick.sv
module evtmr_tick
  import evtmr_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] pre,
  output logic          tick
);
  localparam int DIV_W = (1 << PW) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;

  assign mask = ~({DIV_W{1'b1}} << pre);
  assign tick = run & ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (restart)  div_d = '0;
    else if (run) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre != '0 && !restart) |=> (!tick || !$stable(pre)));
endmodule

// File: rtl/evtmr_chan.sv
module evtmr_chan
  import evtmr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int DRAIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  ctrl_t            ctrl_wd,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] ivl,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam int DR_W = $clog2(DRAIN + 1);

  ctrl_t            ctrl_d;
  logic [DR_W-1:0]  drain_q, drain_d;
  logic [CNT_W-1:0] cnt_d;
  logic             active, tick;

  assign active = ctrl_q.en | (drain_q != '0);

  evtmr_tick #(.PW(PRE_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .restart (rld_we),
    .pre     (ctrl_q.pre),
    .tick    (tick)
  );

  assign expire = tick & (cnt_q == '0) & ~rld_we;

  always_comb begin
    cnt_d = cnt_q;
    if (rld_we)                       cnt_d = ivl;
    else if (expire)                  cnt_d = ctrl_q.one_shot ? cnt_q : ivl;
    else if (tick)                    cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    drain_d = drain_q;
    if (drain_q != '0) drain_d = drain_q - 1'b1;
    if (ctrl_we) begin
      ctrl_d = ctrl_wd;
      if (ctrl_q.en && !ctrl_wd.en) drain_d = DR_W'(DRAIN);
    end else if (expire && ctrl_q.one_shot) begin
      ctrl_d.en = 1'b0;
      drain_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      drain_q <= '0;
      cnt_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      drain_q <= drain_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !rld_we) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.one_shot) |=> cnt_q == $past(ivl));

  // R6
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.one_shot && !ctrl_we) |=> (!ctrl_q.en && cnt_q == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !rld_we) |=> cnt_q == $past(cnt_q));

  // R7
  drain_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_q.en && !ctrl_wd.en) |=> active);
endmodule

// File: rtl/evtmr_bank.sv
module evtmr_bank
  import evtmr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [NCH-1:0]   irq
);
  localparam int DW    = BUS_W;
  localparam int CNT_W = 2 * DW;

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic           rd_stb, wr_stb, ie_we, st_we, hit_ie, hit_st;
  logic [NCH-1:0] ie_q, ie_d, pend_q, pend_d, expire_v, lo_hit;
  logic [DW-1:0]  shadow_q, shadow_d, rdata_q, rdata_d, rd_d;
  logic [DW-1:0]  ch_rd [NCH];
  logic [DW-1:0]  ch_hi [NCH];

  assign rd_stb = bus_sel & ~bus_wr;
  assign wr_stb = bus_sel &  bus_wr;
  assign hit_ie = bus_addr == AW'(OFS_IE);
  assign hit_st = bus_addr == AW'(OFS_ST);
  assign ie_we  = wr_stb & hit_ie;
  assign st_we  = wr_stb & hit_st;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(OFS_CH0 + CH_STRIDE * n);

    logic             hit_ctrl, hit_il, hit_ih, hit_cl, hit_ch;
    logic [DW-1:0]    ivl_lo_q, ivl_lo_d, ivl_hi_q, ivl_hi_d;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;

    assign hit_ctrl = bus_addr == BASE + AW'(SUB_CTRL);
    assign hit_il   = bus_addr == BASE + AW'(SUB_IVL_LO);
    assign hit_ih   = bus_addr == BASE + AW'(SUB_IVL_HI);
    assign hit_cl   = bus_addr == BASE + AW'(SUB_CNT_LO);
    assign hit_ch   = bus_addr == BASE + AW'(SUB_CNT_HI);

    always_comb begin
      ivl_lo_d = (wr_stb && hit_il) ? bus_wdata : ivl_lo_q;
      ivl_hi_d = (wr_stb && hit_ih) ? bus_wdata : ivl_hi_q;
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        ivl_lo_q <= '0;
        ivl_hi_q <= '0;
      end else begin
        ivl_lo_q <= ivl_lo_d;
        ivl_hi_q <= ivl_hi_d;
      end
    end

    evtmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .ctrl_we (wr_stb & hit_ctrl),
      .ctrl_wd (ctrl_unpack(bus_wdata)),
      .rld_we  (wr_stb & hit_ctrl & bus_wdata[BIT_RLD]),
      .ivl     ({ivl_hi_q, ivl_lo_q}),
      .ctrl_q  (ctrl_q),
      .cnt_q   (cnt_q),
      .expire  (expire_v[n])
    );

    assign ch_rd[n] = hit_ctrl ? ctrl_pack(ctrl_q) :
                      hit_il   ? ivl_lo_q :
                      hit_ih   ? ivl_hi_q :
                      hit_cl   ? cnt_q[DW-1:0] :
                      hit_ch   ? shadow_q : '0;
    assign lo_hit[n] = rd_stb & hit_cl;
    assign ch_hi[n]  = cnt_q[CNT_W-1:DW];

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      expire_v[n] |=> pend_q[n]);

    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      (st_we && bus_wdata[n] && !expire_v[n]) |=> !pend_q[n]);

    // R11
    shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      lo_hit[n] |=> shadow_q == $past(ch_hi[n]));
  end

  always_comb begin
    rd_d = '0;
    if (hit_ie) rd_d = {{(DW-NCH){1'b0}}, ie_q};
    if (hit_st) rd_d = {{(DW-NCH){1'b0}}, pend_q};
    for (int n = 0; n < NCH; n++) rd_d = rd_d | ch_rd[n];
    shadow_d = shadow_q;
    for (int n = 0; n < NCH; n++) if (lo_hit[n]) shadow_d = ch_hi[n];
    rdata_d = rd_stb ? rd_d : rdata_q;
    ie_d    = ie_we ? bus_wdata[NCH-1:0] : ie_q;
    pend_d  = (pend_q & ~(st_we ? bus_wdata[NCH-1:0] : '0)) | expire_v;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ie_q     <= '0;
      pend_q   <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      ie_q     <= ie_d;
      pend_q   <= pend_d;
      shadow_q <= shadow_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = pend_q & ie_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_stb |=> $stable(bus_rdata));
endmodule

// File: tb/evtmr_bank_tb_top.sv
`timescale 1ns/1ps
module evtmr_bank_tb_top;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_sel, bus_wr;
  logic [11:0]    bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic [NCH-1:0] irq;

  always #2.5 clk = ~clk;

  evtmr_bank #(.NCH(NCH), .AW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_due = 1'b0;
  bit          done = 1'b0;

  function automatic int ca(input int ch, input int sub);
    return 'h10 + 'h20 * ch + sub;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 1'b0;
    rd_due = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compare each read result on the falling edge after it arrives
  always @(negedge clk) begin
    if (rd_due) begin
      rd_due = 1'b0;
      chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 irq after reset", {28'h0, irq}, 32'h0);
    rd('h00, 32'h0, "R1 ie reset");
    rd('h04, 32'h0, "R1 status reset");
    rd(ca(0, 'h0), 32'h0, "R1 ctrl reset");
    rd(ca(3, 'hC), 32'h0, "R1 count reset");

    // A: ch0 periodic, prescale 0, low-only interval (R3, R2, R7, R10)
    wr(ca(0, 'h4), 32'd100);
    wr(ca(0, 'h0), 32'h3);              // E0: enable + reload
    idle(9);
    rd(ca(0, 'hC), 32'd91, "R3 count after 10 edges");
    rd(ca(0, 'h0), 32'h1, "R2 reload bit reads 0");
    wr(ca(0, 'h0), 32'h0);              // E12: disable
    idle(4);
    rd(ca(0, 'hC), 32'd86, "R7 two extra counts after disable");
    idle(3);
    rd(ca(0, 'hC), 32'd86, "R7 count holds once stopped");

    // B: ch1 prescale 2 (R4)
    wr(ca(1, 'h4), 32'd1000);
    wr(ca(1, 'h0), 32'h23);
    idle(15);
    rd(ca(1, 'hC), 32'd997, "R4 one count per four edges");
    rd(ca(1, 'hC), 32'd996, "R4 fourth tick lands");

    // C: ch2 periodic expiry, interrupt, status clear (R5, R8, R9, R7)
    wr('h00, 32'h4);
    wr(ca(2, 'h4), 32'd3);
    wr(ca(2, 'h0), 32'h3);              // E0
    idle(4);
    rd('h04, 32'h4, "R5 pending after expiry");
    rd(ca(2, 'hC), 32'd2, "R5 interval reloaded and counting");
    chk("R8 irq high with pending and enable", {31'h0, irq[2]}, 32'h1);
    wr('h04, 32'h4);                    // E7 clear
    rd('h04, 32'h0, "R9 write one clears");
    rd('h04, 32'h4, "R5 next period expires");
    wr('h04, 32'h0);
    rd('h04, 32'h4, "R9 write zero no effect");
    wr(ca(2, 'h0), 32'h0);              // E12 disable, expires on same edge
    wr('h04, 32'h4);
    rd('h04, 32'h0, "R9 cleared again");
    chk("R8 irq low once cleared", {31'h0, irq[2]}, 32'h0);
    rd(ca(2, 'hC), 32'd1, "R7 stopped after drain");

    // D: ch3 one-shot with interrupt disabled (R6, R8)
    wr(ca(3, 'h4), 32'd2);
    wr(ca(3, 'h0), 32'h83);             // E0
    idle(5);
    rd('h04, 32'h8, "R8 pending set with interrupt disabled");
    chk("R8 irq low while disabled", {31'h0, irq[3]}, 32'h0);
    rd(ca(3, 'h0), 32'h80, "R6 enable cleared by one-shot");
    rd(ca(3, 'hC), 32'h0, "R6 count holds zero");
    wr('h00, 32'hC);
    chk("R8 irq rises on enable", {31'h0, irq[3]}, 32'h1);
    wr('h04, 32'h8);
    chk("R8 irq falls on clear", {31'h0, irq[3]}, 32'h0);

    // R12 independence
    rd(ca(1, 'h0), 32'h21, "R12 ch1 control untouched");
    rd(ca(0, 'hC), 32'd86, "R12 ch0 count untouched");

    // E: ch0 64-bit interval, borrow and shadow (R10, R11, R2)
    wr(ca(0, 'h4), 32'h1);
    wr(ca(0, 'h8), 32'h1);
    rd(ca(0, 'h8), 32'h1, "R2 interval high word");
    wr(ca(0, 'h0), 32'h3);              // E0
    rd(ca(0, 'hC), 32'h1, "R10 low word after 64-bit reload");
    idle(3);
    rd(ca(0, 'h10), 32'h1, "R11 high read returns shadow");
    rd(ca(0, 'hC), 32'hFFFF_FFFC, "R10 borrow across word boundary");
    rd(ca(0, 'h10), 32'h0, "R11 shadow follows latest low read");

    idle(3);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule